// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Chip-Select Decoder

This block sits between an 8-bit processor and its memories and peripheral. On that processor the eight low address lines share their pins with the data bus. The block captures the low address byte while the address-latch-enable strobe is high and holds it after the strobe falls. It joins that byte with the directly driven upper byte to form a stable 16-bit address for the whole bus cycle.

From this address and the memory/IO select line, the block drives active-low chip selects. In memory cycles it drives one select for an 8K ROM and one for an 8K RAM. In I/O cycles it drives one-hot selects for four peripheral registers. It also passes the processor's read and write strobes through with qualification, so that the two outputs are never active together.

The latch is modelled with a clock. While the enable is high, the low address output follows the bus directly. The held copy is updated on every rising clock edge at which the enable is high. The enable must therefore stay high across at least one rising clock edge in each bus cycle.

Top module: `bus_demux_decoder`

## Requirements
- R1: While `ale` is 1 and `rst` is 0, `addr[7:0]` equals `ad_bus` in the same cycle.
- R2: Once `ale` is 0, `addr[7:0]` holds the value `ad_bus` had at the last rising clock edge with `ale` = 1. Later changes on `ad_bus` (the data phase) do not move it.
- R3: `addr[15:8]` always equals `addr_hi`.
- R4: `rom_cs_n` is 0 exactly when `io_m` = 0, `rst` = 0 and `addr` lies in 0000h..1FFFh, which means bits 15..13 are 000.
- R5: `ram_cs_n` is 0 exactly when `io_m` = 0, `rst` = 0 and `addr` lies in 2000h..3FFFh, which means bits 15..13 are 001. Bit 13 alone separates RAM from ROM.
- R6: When `io_m` = 1, both memory selects are 1. When `io_m` = 0, all four `io_cs_n` bits are 1.
- R7: When `io_m` = 1 and `addr[7:0]` is 80h + k for k in 0..3, bit k of `io_cs_n` is 0 and the other bits are 1. Bit 0 selects port A, bit 1 port B, bit 2 port C and bit 3 the control register. Any other low byte leaves all bits at 1, whatever the upper byte holds.
- R8: At most one of `rom_cs_n`, `ram_cs_n` and `io_cs_n[3:0]` is 0 at any time. A memory address at 4000h or above selects nothing.
- R9: `rd_n` is 0 only when `rd_n_in` = 0 and `wr_n_in` = 1. `wr_n` is 0 only when `wr_n_in` = 0 and `rd_n_in` = 1. If both inputs are 0, both outputs are 1.
- R10: While `rst` = 1, every select and both strobes are 1 and `addr[7:0]` reads 00h. A rising clock edge with `rst` = 1 clears the held low byte to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held low-address register |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address-latch-enable strobe, transparent while high |
| ad_bus | input | 8 | Shared low address / data lines |
| addr_hi | input | 8 | Directly driven upper address byte |
| io_m | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| rd_n_in | input | 1 | Processor read strobe, active low |
| wr_n_in | input | 1 | Processor write strobe, active low |
| addr | output | 16 | Demultiplexed full address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| io_cs_n | output | 4 | Peripheral register selects, active low, one-hot |
| rd_n | output | 1 | Qualified read strobe, active low |
| wr_n | output | 1 | Qualified write strobe, active low |

## Verification
Memory cycles sweep every upper byte against several low bytes. This separates the ROM, RAM and unselected regions through bit 13 and bits 15..14, including the 1FFFh/2000h and 3FFFh/4000h edges. I/O cycles sweep all 256 low bytes with an upper byte that changes across the sweep. This shows that only 80h..83h select a port, that 7Fh and 84h fall outside, and that the upper byte plays no part. Each cycle drives a data value that differs from the address onto the shared lines after the enable falls. A stable address then proves that the held byte, not the bus, feeds the decode. The four strobe combinations, together with a reset taken in the middle of a run, cover the qualification and the clearing of the held byte.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  // True when a low address byte falls inside an I/O register window.
  function automatic logic in_window(input int unsigned value,
                                     input int unsigned base,
                                     input int unsigned count);
    return (value >= base) && (value < base + count);
  endfunction

  // Active-low one-hot vector for a slot index, width up to 32.
  function automatic logic [31:0] onehot_n(input int unsigned idx,
                                           input logic hit);
    logic [31:0] v;
    v = '1;
    if (hit) v[idx[4:0]] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/lo_addr_hold.sv
module lo_addr_hold #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_bus,
  output logic [LO_W-1:0] lo_addr,
  output logic            capture
);
  logic [LO_W-1:0] held_q;

  assign capture = ale && !rst;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '0;
    else if (capture) held_q <= ad_bus;
  end

  // Transparent while the enable is high, held copy afterwards.
  always_comb begin
    if (rst)          lo_addr = '0;
    else if (ale)     lo_addr = ad_bus;
    else              lo_addr = held_q;
  end
endmodule

// File: rtl/mem_decode.sv
module mem_decode #(
  parameter int FIELD_W  = 3,
  parameter int ROM_SLOT = 0,
  parameter int RAM_SLOT = 1
) (
  input  logic               rst,
  input  logic               io_m,
  input  logic [FIELD_W-1:0] field,
  output logic               rom_n,
  output logic               ram_n,
  output logic               outside_hit
);
  localparam int SLOTS = 1 << FIELD_W;

  logic [SLOTS-1:0] slot_n;
  logic [SLOTS-1:0] used_mask;
  logic             enable;

  assign enable = !io_m && !rst;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_n[g]    = !(enable && (field == FIELD_W'(g)));
      assign used_mask[g] = (g == ROM_SLOT) || (g == RAM_SLOT);
    end
  endgenerate

  assign rom_n       = slot_n[ROM_SLOT];
  assign ram_n       = slot_n[RAM_SLOT];
  assign outside_hit = !(&(slot_n | used_mask));
endmodule

// File: rtl/io_decode.sv
module io_decode
  import busdec_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int IO_BASE  = 8'h80,
  parameter int IO_PORTS = 4
) (
  input  logic                rst,
  input  logic                io_m,
  input  logic [LO_W-1:0]     lo_addr,
  output logic [IO_PORTS-1:0] sel_n,
  output logic                io_hit
);
  logic enable;
  assign enable = io_m && !rst;
  assign io_hit = enable && in_window(int'(lo_addr), IO_BASE, IO_PORTS);

  genvar g;
  generate
    for (g = 0; g < IO_PORTS; g++) begin : g_port
      assign sel_n[g] = !(enable && (int'(lo_addr) == IO_BASE + g));
    end
  endgenerate
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate (
  input  logic rst,
  input  logic rd_n_in,
  input  logic wr_n_in,
  output logic rd_n,
  output logic wr_n,
  output logic conflict
);
  assign conflict = !rd_n_in && !wr_n_in;
  assign rd_n     = rst || rd_n_in || conflict;
  assign wr_n     = rst || wr_n_in || conflict;
endmodule

// File: rtl/bus_demux_decoder.sv
module bus_demux_decoder #(
  parameter int ADDR_W   = 16,
  parameter int LO_W     = 8,
  parameter int FIELD_W  = 3,
  parameter int ROM_SLOT = 0,
  parameter int RAM_SLOT = 1,
  parameter int IO_BASE  = 8'h80,
  parameter int IO_PORTS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ale,
  input  logic [LO_W-1:0]     ad_bus,
  input  logic [ADDR_W-LO_W-1:0] addr_hi,
  input  logic                io_m,
  input  logic                rd_n_in,
  input  logic                wr_n_in,
  output logic [ADDR_W-1:0]   addr,
  output logic                rom_cs_n,
  output logic                ram_cs_n,
  output logic [IO_PORTS-1:0] io_cs_n,
  output logic                rd_n,
  output logic                wr_n
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] lo_addr;
  logic            capture;
  logic            outside_hit;
  logic            io_hit;
  logic            strobe_conflict;

  lo_addr_hold #(.LO_W(LO_W)) u_hold (
    .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus),
    .lo_addr(lo_addr), .capture(capture)
  );

  assign addr = {addr_hi[HI_W-1:0], lo_addr};

  mem_decode #(.FIELD_W(FIELD_W), .ROM_SLOT(ROM_SLOT), .RAM_SLOT(RAM_SLOT)) u_mem (
    .rst(rst), .io_m(io_m), .field(addr[ADDR_W-1 -: FIELD_W]),
    .rom_n(rom_cs_n), .ram_n(ram_cs_n), .outside_hit(outside_hit)
  );

  io_decode #(.LO_W(LO_W), .IO_BASE(IO_BASE), .IO_PORTS(IO_PORTS)) u_io (
    .rst(rst), .io_m(io_m), .lo_addr(lo_addr), .sel_n(io_cs_n), .io_hit(io_hit)
  );

  strobe_gate u_strobe (
    .rst(rst), .rd_n_in(rd_n_in), .wr_n_in(wr_n_in),
    .rd_n(rd_n), .wr_n(wr_n), .conflict(strobe_conflict)
  );
endmodule

// File: rtl/bus_demux_decoder_chk.sv
module bus_demux_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int LO_W     = 8,
  parameter int FIELD_W  = 3,
  parameter int IO_BASE  = 8'h80,
  parameter int IO_PORTS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                ale,
  input logic [LO_W-1:0]     ad_bus,
  input logic [ADDR_W-LO_W-1:0] addr_hi,
  input logic                io_m,
  input logic [ADDR_W-1:0]   addr,
  input logic                rom_cs_n,
  input logic                ram_cs_n,
  input logic [IO_PORTS-1:0] io_cs_n,
  input logic                rd_n,
  input logic                wr_n,
  input logic                capture,
  input logic                outside_hit,
  input logic                io_hit,
  input logic                strobe_conflict
);
  // R1
  ale_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> addr[LO_W-1:0] == ad_bus);

  // R2
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!ale && $past(capture)) |-> addr[LO_W-1:0] == $past(ad_bus));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ale && !$past(ale) && !$past(rst)) |-> $stable(addr[LO_W-1:0]));

  // R3
  upper_pass_chk: assert property (@(posedge clk)
    addr[ADDR_W-1:LO_W] == addr_hi);

  // R4
  rom_range_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> (!io_m && addr[ADDR_W-1 -: FIELD_W] == '0));

  // R5
  ram_range_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_cs_n |-> (!io_m && addr[ADDR_W-1 -: FIELD_W] == FIELD_W'(1)));

  // R6
  mem_in_io_chk: assert property (@(posedge clk) disable iff (rst)
    io_m |-> (rom_cs_n && ram_cs_n));

  // R6
  io_in_mem_chk: assert property (@(posedge clk) disable iff (rst)
    !io_m |-> &io_cs_n);

  // R7
  io_port_chk: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> io_cs_n == ~(IO_PORTS'(1) << (addr[LO_W-1:0] - LO_W'(IO_BASE))));

  // R7
  io_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !io_hit |-> &io_cs_n);

  // R8
  one_select_chk: assert property (@(posedge clk)
    $countones({~rom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1);

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    outside_hit |-> (rom_cs_n && ram_cs_n));

  // R9
  strobe_excl_chk: assert property (@(posedge clk)
    strobe_conflict |-> (rd_n && wr_n));

  // R9
  strobe_never_both_chk: assert property (@(posedge clk)
    !(!rd_n && !wr_n));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (rom_cs_n && ram_cs_n && &io_cs_n && rd_n && wr_n
             && addr[LO_W-1:0] == '0));
endmodule

bind bus_demux_decoder bus_demux_decoder_chk #(
  .ADDR_W(ADDR_W), .LO_W(LO_W), .FIELD_W(FIELD_W),
  .IO_BASE(IO_BASE), .IO_PORTS(IO_PORTS)
) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
  .io_m(io_m), .addr(addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
  .io_cs_n(io_cs_n), .rd_n(rd_n), .wr_n(wr_n), .capture(capture),
  .outside_hit(outside_hit), .io_hit(io_hit), .strobe_conflict(strobe_conflict)
);

// File: tb/bus_demux_decoder_test.sv
module bus_demux_decoder_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, ale, io_m, rd_n_in, wr_n_in;
  logic [7:0] ad_bus, addr_hi;
  logic [15:0] addr;
  logic       rom_cs_n, ram_cs_n, rd_n, wr_n;
  logic [3:0] io_cs_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_demux_decoder uut (
    .clk(clk), .rst(rst), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
    .io_m(io_m), .rd_n_in(rd_n_in), .wr_n_in(wr_n_in), .addr(addr),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected selects packed as {rom_n, ram_n, io_n[3:0]}, computed by range.
  function automatic logic [5:0] expect_sel(input logic [15:0] a, input logic iom);
    logic [5:0] e;
    int unsigned lo;
    e  = 6'b111111;
    lo = a % 256;
    if (!iom && a < 16'h2000) e[5] = 1'b0;
    if (!iom && a >= 16'h2000 && a < 16'h4000) e[4] = 1'b0;
    if (iom && lo >= 128 && lo < 132) e[lo - 128] = 1'b0;
    return e;
  endfunction

  task automatic check_sel(input logic [15:0] a, input logic iom, input string tag);
    logic [5:0] got, exp;
    got = {rom_cs_n, ram_cs_n, io_cs_n};
    exp = expect_sel(a, iom);
    check(got == exp, tag, 32'(got), 32'(exp));
    check($countones(~got) <= 1, "R8 one select", 32'(got), 32'(exp));
  endtask

  // One multiplexed bus cycle: address phase, then two data phases.
  task automatic bus_cycle(input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] dat, input logic iom, input string tag);
    logic [15:0] a;
    a = {hi, lo};
    @(negedge clk);
    ale = 1'b1; ad_bus = lo; addr_hi = hi; io_m = iom;
    #1 check(addr[7:0] == lo, "R1 follow", 32'(addr[7:0]), 32'(lo));
    @(negedge clk);
    ale = 1'b0; ad_bus = dat;
    #1 check(addr == a, "R2/R3 hold", 32'(addr), 32'(a));
    check_sel(a, iom, tag);
    @(negedge clk);
    ad_bus = ~dat;
    #1 check(addr == a, "R2 stable", 32'(addr), 32'(a));
    check_sel(a, iom, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; ale = 1'b1; ad_bus = 8'h5A; addr_hi = 8'h00; io_m = 1'b0;
    rd_n_in = 1'b0; wr_n_in = 1'b1;
    repeat (2) @(negedge clk);
    #1 check({rom_cs_n, ram_cs_n, io_cs_n, rd_n, wr_n} == 8'hFF, "R10 reset quiet",
             32'({rom_cs_n, ram_cs_n, io_cs_n, rd_n, wr_n}), 32'hFF);
    check(addr[7:0] == 8'h00, "R10 reset low byte", 32'(addr[7:0]), 0);
    @(negedge clk); ale = 1'b0; rd_n_in = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 check(addr == 16'h0000, "R10 cleared hold", 32'(addr), 0);
    check_sel(16'h0000, 1'b0, "R4 after reset");

    // Memory sweep: every upper byte against several low bytes (R4 R5 R8).
    for (int h = 0; h < 256; h++) begin
      bus_cycle(8'(h), 8'h00, 8'hC3, 1'b0, "R4/R5 mem sweep lo00");
      bus_cycle(8'(h), 8'hFF, 8'h3C, 1'b0, "R4/R5 mem sweep loFF");
    end
    // Named memory boundaries (R4 R5 R8).
    bus_cycle(8'h1F, 8'hFF, 8'h00, 1'b0, "R4 1FFF");
    bus_cycle(8'h20, 8'h00, 8'hFF, 1'b0, "R5 2000");
    bus_cycle(8'h3F, 8'hFF, 8'h00, 1'b0, "R5 3FFF");
    bus_cycle(8'h40, 8'h00, 8'hFF, 1'b0, "R8 4000 none");
    // Memory addresses in I/O cycles select no memory (R6).
    bus_cycle(8'h00, 8'h10, 8'h99, 1'b1, "R6 rom addr io");
    bus_cycle(8'h21, 8'h83, 8'h99, 1'b1, "R6 ram addr io");
    // I/O sweep: all low bytes, upper byte varying (R7).
    for (int l = 0; l < 256; l++)
      bus_cycle(8'(l * 37 + 5), 8'(l), 8'(~l), 1'b1, "R7 io sweep");
    bus_cycle(8'h00, 8'h7F, 8'h80, 1'b1, "R7 7F none");
    bus_cycle(8'hFF, 8'h80, 8'h7F, 1'b1, "R7 80 port A");
    bus_cycle(8'h12, 8'h83, 8'h84, 1'b1, "R7 83 control");
    bus_cycle(8'h00, 8'h84, 8'h83, 1'b1, "R7 84 none");
    // I/O-window low byte in memory cycle selects no port (R6).
    bus_cycle(8'h30, 8'h81, 8'h00, 1'b0, "R6 io byte in mem");

    // Strobe qualification (R9).
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rd_n_in = k[0]; wr_n_in = k[1];
      #1 check(rd_n == !(!k[0] && k[1]), "R9 rd_n", 32'(rd_n), 32'(!(!k[0] && k[1])));
      check(wr_n == !(!k[1] && k[0]), "R9 wr_n", 32'(wr_n), 32'(!(!k[1] && k[0])));
    end

    // Mid-run reset clears the held byte (R10).
    bus_cycle(8'h05, 8'hAB, 8'h11, 1'b0, "R4 pre-reset");
    @(negedge clk); rst = 1'b1; rd_n_in = 1'b0; wr_n_in = 1'b1;
    #1 check({rom_cs_n, ram_cs_n, io_cs_n, rd_n, wr_n} == 8'hFF, "R10 mid reset quiet",
             32'({rom_cs_n, ram_cs_n, io_cs_n, rd_n, wr_n}), 32'hFF);
    @(negedge clk); rst = 1'b0; rd_n_in = 1'b1;
    #1 check(addr == 16'h0500, "R10 hold cleared mid-run", 32'(addr), 32'h0500);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule